// File: doc/BRIEF.md
# Serial Link Frame Builder

The block produces an endless stream of fixed 50-byte frames for a transceiver PCS, one byte per clock together with a flag that marks K-characters. Each frame opens with a timing marker and a protocol identifier byte, followed by four packets. A packet carries an address, ten payload bytes and a control byte. The control byte holds two parity bits computed from the address and payload, plus a sideband nibble.

The packet contents come from a local source through a small interface. When the block is about to send a packet's address, it raises `pkt_req` for one cycle and names the packet slot on `pkt_idx`. In that cycle it captures the address, payload and sideband nibble. The choice of marker for each frame comes from free-running counters that mark 2 µs, 1 ms and 1 s boundaries in whole frames. An external PPS pulse restarts these counters at the next frame boundary.

Top module: `link_frame_builder`

## Requirements
- R1: Every frame is exactly 50 bytes long. `tx_is_k` is high only on the first byte of each frame, so a marker appears once every 50 cycles.
- R2: The byte after the marker is 0x00 when `proto_other` is high and 0xAA when it is low.
- R3: The marker byte is 0x7C on a 1 s boundary, 0x5C on a 1 ms boundary, 0x3C on a 2 µs boundary and 0xBC otherwise. When boundaries coincide, the longest period wins.
- R4: Boundaries are counted in frames. A 2 µs boundary falls every TICK_FRAMES frames, a 1 ms boundary every MS_TICKS of those, and a 1 s boundary every S_MS milliseconds. The frame index 0 counted from reset is a boundary of all three kinds.
- R5: Before each of the four packets, `pkt_req` is high for one cycle with `pkt_idx` = 0..3 in order. The address presented in that cycle is the next output byte. After it come the ten payload bytes captured in the same cycle, byte 0 (`pkt_payload[7:0]`) first.
- R6: The twelfth byte of each packet is the control byte. Its bit 7 is the XOR of bits 1, 3, 5 and 7 of the address and the ten payload bytes. Its bit 6 is the XOR of bits 0, 2, 4 and 6 of the same bytes. Bits 5:4 are 0 and bits 3:0 are the sideband nibble captured with the packet.
- R7: A PPS pulse that arrives inside a frame makes the next frame carry 0x7C. Boundary counting then restarts as if that frame were frame 0 after reset.
- R8: During reset, `tx_data` is 0x00 and `tx_is_k` and `pkt_req` are low. The first frame after reset carries 0x7C.
- R9: Changes to `pkt_addr`, `pkt_payload` and `pkt_side` outside the `pkt_req` cycle have no effect on the packet being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pps | input | 1 | Pulse that restarts the timing counters |
| proto_other | input | 1 | Selects the foreign protocol identifier |
| pkt_addr | input | 8 | Packet address from the source |
| pkt_payload | input | 80 | Ten payload bytes, byte 0 in bits 7:0 |
| pkt_side | input | 4 | Sideband nibble for the control byte |
| pkt_req | output | 1 | Capture strobe for the packet inputs |
| pkt_idx | output | 2 | Packet slot being requested |
| tx_data | output | 8 | Byte to the PCS |
| tx_is_k | output | 1 | High when `tx_data` is a K-character |

## Verification
The bench builds the block with TICK_FRAMES = 2, MS_TICKS = 3 and S_MS = 2, so 2 µs boundaries fall every 2 frames, millisecond boundaries every 6 and second boundaries every 12. With these values, fourteen consecutive frames show every marker kind, both coincidence priorities and the wrap of the slowest counter. At the default values, reaching the second marker would take millions of frames. A PPS pulse mid-frame then shows that the restart lands on the next frame.

// File: rtl/link_frame_builder.sv
module link_frame_builder #(
  parameter int TICK_FRAMES = 5,
  parameter int MS_TICKS    = 500,
  parameter int S_MS        = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pps,
  input  logic        proto_other,
  input  logic [7:0]  pkt_addr,
  input  logic [79:0] pkt_payload,
  input  logic [3:0]  pkt_side,
  output logic        pkt_req,
  output logic [1:0]  pkt_idx,
  output logic [7:0]  tx_data,
  output logic        tx_is_k
);
  localparam int FW = (TICK_FRAMES > 1) ? $clog2(TICK_FRAMES) : 1;
  localparam int TW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam int MW = (S_MS > 1) ? $clog2(S_MS) : 1;
  localparam logic [7:0] K_SOF = 8'hBC, K_2US = 8'h3C, K_MS = 8'h5C, K_SEC = 8'h7C;
  localparam logic [87:0] ODD_MASK = {11{8'hAA}};

  typedef enum logic [2:0] {S_MARK, S_PID, S_ADDR, S_DATA, S_CTRL} state_t;
  state_t      st;
  logic [1:0]  pidx;
  logic [3:0]  dcnt;
  logic [7:0]  sh_addr;
  logic [79:0] sh_pay;
  logic [3:0]  sh_side;
  logic        pps_pend, ctrl_out;
  logic [FW-1:0] fcnt;
  logic [TW-1:0] tcnt;
  logic [MW-1:0] mcnt;

  assign pkt_req = (st == S_ADDR);
  assign pkt_idx = pidx;

  logic          restart, b2us, bms, bsec, f_wrap, t_wrap, m_wrap;
  logic [FW-1:0] ef;
  logic [TW-1:0] et;
  logic [MW-1:0] em;
  logic [7:0]    marker;
  logic          par_o, par_e;

  assign restart = pps_pend | pps;
  assign ef = restart ? '0 : fcnt;
  assign et = restart ? '0 : tcnt;
  assign em = restart ? '0 : mcnt;
  assign b2us = (ef == '0);
  assign bms  = b2us && (et == '0);
  assign bsec = bms && (em == '0);
  assign marker = bsec ? K_SEC : bms ? K_MS : b2us ? K_2US : K_SOF;
  assign f_wrap = (ef == FW'(TICK_FRAMES - 1));
  assign t_wrap = (et == TW'(MS_TICKS - 1));
  assign m_wrap = (em == MW'(S_MS - 1));
  assign par_o = ^({sh_pay, sh_addr} & ODD_MASK);
  assign par_e = ^({sh_pay, sh_addr} & ~ODD_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_MARK; pidx <= '0; dcnt <= '0;
      sh_addr <= '0; sh_pay <= '0; sh_side <= '0;
      tx_data <= '0; tx_is_k <= 1'b0; ctrl_out <= 1'b0;
      pps_pend <= 1'b0; fcnt <= '0; tcnt <= '0; mcnt <= '0;
    end else begin
      tx_is_k  <= (st == S_MARK);
      ctrl_out <= (st == S_CTRL);
      if (st == S_MARK) pps_pend <= 1'b0;
      else if (pps)     pps_pend <= 1'b1;
      case (st)
        S_MARK: begin
          tx_data <= marker;
          fcnt <= f_wrap ? '0 : ef + 1'b1;
          tcnt <= et;
          mcnt <= em;
          if (f_wrap) begin
            tcnt <= t_wrap ? '0 : et + 1'b1;
            if (t_wrap) mcnt <= m_wrap ? '0 : em + 1'b1;
          end
          st <= S_PID;
        end
        S_PID: begin
          tx_data <= proto_other ? 8'h00 : 8'hAA;
          st <= S_ADDR;
        end
        S_ADDR: begin
          tx_data <= pkt_addr;
          sh_addr <= pkt_addr; sh_pay <= pkt_payload; sh_side <= pkt_side;
          dcnt <= '0;
          st <= S_DATA;
        end
        S_DATA: begin
          tx_data <= sh_pay[dcnt*8 +: 8];
          dcnt <= dcnt + 1'b1;
          if (dcnt == 4'd9) st <= S_CTRL;
        end
        default: begin
          tx_data <= {par_o, par_e, 2'b00, sh_side};
          pidx <= pidx + 1'b1;
          st <= (pidx == 2'd3) ? S_MARK : S_ADDR;
        end
      endcase
    end
  end

  assert_marker_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_is_k |-> (tx_data == K_SOF || tx_data == K_2US || tx_data == K_MS || tx_data == K_SEC));
  assert_pid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_is_k |=> (!tx_is_k && (tx_data == 8'hAA || tx_data == 8'h00)));
  assert_addr_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req |=> (tx_data == $past(pkt_addr) && !tx_is_k));
  assert_ctrl_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out |-> (tx_data[5:4] == 2'b00 && !tx_is_k));
  assert_pps_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_pend && st == S_MARK) |=> (tx_is_k && tx_data == K_SEC));
endmodule

// File: tb/sim_link_frame_builder.sv
`timescale 1ns/1ps
module sim_link_frame_builder;
  localparam int TF = 2, MT = 3, SM = 2;
  logic clk = 0, rst_n = 0, pps = 0, proto_other = 0;
  logic [7:0] pkt_addr;
  logic [79:0] pkt_payload;
  logic [3:0] pkt_side;
  logic pkt_req, tx_is_k;
  logic [1:0] pkt_idx;
  logic [7:0] tx_data;
  int checks = 0, errors = 0, cyc = 0, base = 0;
  logic [7:0] src_seed = 8'h00;
  logic scramble = 0;

  link_frame_builder #(.TICK_FRAMES(TF), .MS_TICKS(MT), .S_MS(SM)) u0 (
    .clk, .rst_n, .pps, .proto_other, .pkt_addr, .pkt_payload, .pkt_side,
    .pkt_req, .pkt_idx, .tx_data, .tx_is_k);

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc++;

  function automatic logic [7:0] f_addr(logic [7:0] s, int p);
    return s ^ 8'(p * 8'h35);
  endfunction
  function automatic logic [7:0] f_pay(logic [7:0] s, int p, int k);
    return 8'(s * 7 + p * 16 + k * 3) ^ 8'h5A;
  endfunction
  function automatic logic [3:0] f_side(logic [7:0] s, int p);
    return 4'(s + 8'(p));
  endfunction
  function automatic logic [7:0] exp_marker(int ph);
    if (ph % (TF * MT * SM) == 0) return 8'h7C;
    if (ph % (TF * MT) == 0) return 8'h5C;
    if (ph % TF == 0) return 8'h3C;
    return 8'hBC;
  endfunction

  always_comb begin
    logic [7:0] a; logic [79:0] pl; logic [3:0] sd;
    a = f_addr(src_seed, int'(pkt_idx));
    for (int k = 0; k < 10; k++) pl[k*8 +: 8] = f_pay(src_seed, int'(pkt_idx), k);
    sd = f_side(src_seed, int'(pkt_idx));
    if (scramble && !pkt_req) begin a = ~a; pl = ~pl; sd = ~sd; end
    pkt_addr = a; pkt_payload = pl; pkt_side = sd;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_data == 8'h00, "R8 reset data", tx_data, 0);
    chk(!tx_is_k && !pkt_req, "R8 reset flags", {tx_is_k, pkt_req}, 0);
    rst_n = 1;
  endtask

  task automatic t_frames(input int count, input logic [7:0] seed);
    for (int f = 0; f < count; f++) begin
      logic [7:0] s, b, po, pe;
      int n, kcnt;
      do @(negedge clk); while (!tx_is_k);
      n = (cyc - 1) / 50;
      s = seed + 8'(f);
      src_seed = s;
      chk(tx_data == exp_marker(n - base), "R3/R4/R7 marker", tx_data, exp_marker(n - base));
      if (n == 0) chk(tx_data == 8'h7C, "R8 first marker", tx_data, 8'h7C);
      kcnt = 0;
      @(negedge clk);
      kcnt += tx_is_k;
      b = proto_other ? 8'h00 : 8'hAA;
      chk(tx_data == b, "R2 protocol id", tx_data, b);
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        kcnt += tx_is_k;
        chk(tx_data == f_addr(s, p), scramble ? "R9 address" : "R5 address", tx_data, f_addr(s, p));
        po = '0; pe = '0;
        for (int j = 0; j < 8; j += 2) begin pe ^= f_addr(s, p)[j]; po ^= f_addr(s, p)[j+1]; end
        for (int k = 0; k < 10; k++) begin
          @(negedge clk);
          kcnt += tx_is_k;
          b = f_pay(s, p, k);
          chk(tx_data == b, scramble ? "R9 payload" : "R5 payload", tx_data, b);
          for (int j = 0; j < 8; j += 2) begin pe ^= b[j]; po ^= b[j+1]; end
        end
        @(negedge clk);
        kcnt += tx_is_k;
        b = {po[0], pe[0], 2'b00, f_side(s, p)};
        chk(tx_data == b, "R6 control byte", tx_data, b);
      end
      chk(kcnt == 0, "R1 K flag outside marker", kcnt, 0);
      @(posedge clk); #1;
      chk(tx_is_k, "R1 frame length", tx_is_k, 1);
    end
  endtask

  task automatic t_pps();
    int n;
    do @(negedge clk); while (!tx_is_k);
    n = (cyc - 1) / 50;
    repeat (10) @(negedge clk);
    pps = 1;
    @(negedge clk);
    pps = 0;
    base = n + 1;
    t_frames(3, 8'hC3);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_frames(14, 8'h11);
        proto_other = 1;
        t_frames(1, 8'h40);
        proto_other = 0;
        scramble = 1;
        t_frames(2, 8'h77);
        scramble = 0;
        t_pps();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule